// File: doc/BRIEF.md
# Shift-Register Program Counter

This block holds the fetch address of a small processor. It does not add one to move to the next instruction. It steps a 12-bit maximal-length linear feedback shift register. The feedback needs only three XOR gates in place of a full incrementer. Because of this, program order follows the register's pseudo-random sequence instead of binary order. An assembler must place the instructions along that sequence.

The surrounding core drives a step enable for each instruction that completes. It can also load an absolute target, which is used for jumps. A conditional-skip request passes over the next instruction without any address field. When the skip is raised together with step, the counter moves two places along the sequence in one cycle.

The block also presents a lookahead address, two places ahead of the current one. Fetch logic can use it to prefetch. The register never enters the all-zero lock-up state.

Top module: `lfsr_pc`

## Requirements
- R1: While rst_ni is low, and after it is released, pc_o holds the seed value 12'h001 until the first step or load.
- R2: With step_i high and skip_i and load_i low, the next pc_o is one shift step of the current value. The step is {pc[10:0], pc[11]^pc[10]^pc[9]^pc[3]}, which is the polynomial x^12+x^11+x^10+x^4+1.
- R3: With step_i and load_i both low, pc_o keeps its value. A skip_i raised alone is ignored.
- R4: With step_i and skip_i high and load_i low, the next pc_o is two shift steps past the current value.
- R5: With load_i high and target_i non-zero, the next pc_o equals target_i. This holds whatever step_i and skip_i are.
- R6: With load_i high and target_i equal to zero, the next pc_o is the seed 12'h001.
- R7: pc_ahead_o always equals two shift steps applied to the current pc_o.
- R8: Stepping from the seed visits 4095 distinct non-zero addresses and then returns to the seed.
- R9: pc_o is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance to the next instruction |
| skip_i | input | 1 | Pass over the next instruction; acts only together with step_i |
| load_i | input | 1 | Load an absolute jump target |
| target_i | input | 12 | Jump target address |
| pc_o | output | 12 | Current fetch address |
| pc_ahead_o | output | 12 | Address two places ahead in the sequence |

## Verification
The bench first steps through the whole sequence from the seed. It checks every transition and every lookahead value against an arithmetic model of the polynomial. It counts how many distinct addresses appear before the seed comes back, so a wrong tap or a short cycle shows up as a count other than 4095. Runs of skip-plus-step are then compared with a double step, which tells a real skip apart from a single step or a hold. Loads of non-zero and zero targets are made with step and skip also raised, which separates load priority from advance priority and shows the zero-to-seed guard. Idle cycles with only skip raised confirm that skip alone does not move the counter.

// File: rtl/lfsr_pc_pkg.sv
package lfsr_pc_pkg;
  typedef enum logic [1:0] {
    ADV_HOLD = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_TWO  = 2'd2,
    ADV_LOAD = 2'd3
  } adv_e;
endpackage

// File: rtl/lfsr_pc_step.sv
module lfsr_pc_step #(
  parameter int unsigned           W    = 12,
  parameter logic [W-1:0]          TAPS = 12'hE08
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] q_o
);
  // Fibonacci form: shift left, parity of tapped bits enters at bit 0
  assign q_o = {q_i[W-2:0], ^(q_i & TAPS)};
endmodule

// File: rtl/lfsr_pc_sel.sv
module lfsr_pc_sel
  import lfsr_pc_pkg::*;
#(
  parameter int unsigned  W    = 12,
  parameter logic [W-1:0] SEED = 12'h001
) (
  input  adv_e         mode_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] one_i,
  input  logic [W-1:0] two_i,
  input  logic [W-1:0] tgt_i,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    unique case (mode_i)
      ADV_ONE:  nxt_o = one_i;
      ADV_TWO:  nxt_o = two_i;
      ADV_LOAD: nxt_o = (tgt_i == '0) ? SEED : tgt_i;  // avoid lock-up state
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/lfsr_pc.sv
module lfsr_pc
  import lfsr_pc_pkg::*;
#(
  parameter int unsigned          ADDR_W = 12,
  parameter logic [ADDR_W-1:0]    TAPS   = 12'hE08,
  parameter logic [ADDR_W-1:0]    SEED   = 12'h001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              skip_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_ahead_o
);
  localparam int unsigned N_AHEAD = 2;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] chain [N_AHEAD+1];
  adv_e              mode;

  assign chain[0] = pc_q;

  for (genvar g = 0; g < N_AHEAD; g++) begin : g_step
    lfsr_pc_step #(.W(ADDR_W), .TAPS(TAPS)) i_step (
      .q_i (chain[g]),
      .q_o (chain[g+1])
    );
  end

  always_comb begin
    if (load_i)                mode = ADV_LOAD;
    else if (step_i && skip_i) mode = ADV_TWO;
    else if (step_i)           mode = ADV_ONE;
    else                       mode = ADV_HOLD;
  end

  lfsr_pc_sel #(.W(ADDR_W), .SEED(SEED)) i_sel (
    .mode_i (mode),
    .cur_i  (pc_q),
    .one_i  (chain[1]),
    .two_i  (chain[N_AHEAD]),
    .tgt_i  (target_i),
    .nxt_o  (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= SEED;
    else         pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_ahead_o = chain[N_AHEAD];

  assert_never_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o != '0);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(pc_o));

  assert_skip_two_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && skip_i && !load_i) |=> pc_o == $past(pc_ahead_o));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && target_i != '0) |=> pc_o == $past(target_i));

  assert_load_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && target_i == '0) |=> pc_o == SEED);

  assert_ahead_moves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ahead_o != pc_o);
endmodule

// File: tb/test_lfsr_pc.sv
module test_lfsr_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, skip = 1'b0, load = 1'b0;
  logic [11:0] tgt = '0;
  logic [11:0] pc, ahead;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lfsr_pc i_lfsr_pc (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .skip_i(skip),
    .load_i(load), .target_i(tgt), .pc_o(pc), .pc_ahead_o(ahead)
  );

  function automatic logic [11:0] m_step(input logic [11:0] v);
    return {v[10:0], v[11] ^ v[10] ^ v[9] ^ v[3]};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive after a negedge, let one posedge pass, sample at the next negedge
  task automatic cyc(input logic st, input logic sk, input logic ld, input logic [11:0] t);
    step = st; skip = sk; load = ld; tgt = t;
    @(negedge clk);
    step = 1'b0; skip = 1'b0; load = 1'b0; tgt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp_pc;
    bit          seen [4096];
    int          distinct;
    @(negedge clk);
    chk("R1 in reset", pc, 12'h001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pc, 12'h001);
    chk("R7 at seed", ahead, m_step(m_step(12'h001)));

    // full period sweep
    distinct = 0;
    exp_pc = 12'h001;
    for (int i = 0; i < 4095; i++) begin
      if (!seen[pc]) begin seen[pc] = 1'b1; distinct++; end
      if (pc == '0) chk("R9 nonzero", pc, 12'h001);
      chk("R7 sweep", ahead, m_step(m_step(pc)));
      exp_pc = m_step(pc);
      cyc(1'b1, 1'b0, 1'b0, '0);
      chk("R2 step", pc, exp_pc);
    end
    chk("R8 back at seed", pc, 12'h001);
    chk("R8 distinct count", 12'(distinct), 12'd4095);

    // skip alone ignored, idle holds
    exp_pc = pc;
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R3 skip alone", pc, exp_pc);
    cyc(1'b0, 1'b0, 1'b0, 12'hABC);
    chk("R3 idle", pc, exp_pc);

    // skip+step double advances
    for (int i = 0; i < 64; i++) begin
      exp_pc = m_step(m_step(pc));
      cyc(1'b1, 1'b1, 1'b0, '0);
      chk("R4 skip step", pc, exp_pc);
      chk("R7 after skip", ahead, m_step(m_step(pc)));
    end

    // loads with step/skip also raised
    for (int i = 1; i < 4096; i += 257) begin
      cyc(1'b1, 1'(i & 1), 1'b1, 12'(i));
      chk("R5 load priority", pc, 12'(i));
      chk("R7 after load", ahead, m_step(m_step(12'(i))));
    end
    cyc(1'b0, 1'b0, 1'b1, 12'hFFF);
    chk("R5 load all ones", pc, 12'hFFF);
    cyc(1'b1, 1'b1, 1'b1, 12'h000);
    chk("R6 load zero", pc, 12'h001);
    cyc(1'b0, 1'b0, 1'b1, 12'h800);
    cyc(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R6 load zero plain", pc, 12'h001);

    // mid-run reset
    cyc(1'b1, 1'b0, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", pc, 12'h001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after second release", pc, 12'h001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule